// File: doc/BRIEF.md
# Auto-Incrementing Register Access Window

This block sits between a small sequencing controller and two back ends: a 16-bit-addressed register bus and a 64-bit-addressed memory port. The controller sees only three strobes: load the pointer, write data, and read. It loads a target register number into the pointer once. After that, every data write becomes a register-bus write to the pointed register and every read fetches that register. The pointer steps by one after each access, so a run of neighbouring registers can be streamed without reloading it.

Three pointer values are reserved for memory access. Data writes at the low and high address locations load a 64-bit memory pointer one 32-bit half at a time. At the memory data location, data writes become memory writes and reads become memory reads. The register pointer stays on that location, and the memory pointer advances by one word (4 bytes) per access. Reads of either kind return through a valid pulse. The controller is held off by a busy flag until the response arrives.

Top module: `regwin_bridge`

## Requirements
- R1: After synchronous active-low reset, the register pointer and memory pointer are zero, no bus or memory strobe is active, and busy and read-valid are low.
- R2: A pointer-load strobe copies ctl_wdata[15:0] into the register pointer and produces no bus or memory strobe.
- R3: A data-write strobe at an ordinary pointer value raises bus_wr for one cycle, starting on the cycle after the strobe, with the current pointer and ctl_wdata. The pointer then advances by one.
- R4: A read strobe at an ordinary pointer value raises bus_rd for one cycle after the strobe, at the current pointer, and raises ctl_busy. The pointer advances by one. On the cycle after bus_rvalid, ctl_rvalid pulses with bus_rdata on ctl_rdata and busy drops.
- R5: The register pointer is 16 bits and wraps from 0xFFFF to 0x0000.
- R6: Bit 11 of the pointer selects the register bank: bus_bank carries it (0 for bank 0, 1 for bank 1), and bus_addr carries the pointer with bit 11 cleared.
- R7: A data write at pointer 0x0440 loads memory pointer bits 31:0, and one at 0x0441 loads bits 63:32. Neither produces a bus or memory strobe, and each advances the register pointer.
- R8: A data write at pointer 0x0448 raises mem_wr for one cycle at the memory pointer, with ctl_wdata. The memory pointer then grows by 4 and the register pointer is unchanged.
- R9: A read at pointer 0x0448 raises mem_rd at the memory pointer, waits for mem_rvalid, and returns mem_rdata. The memory pointer grows by 4 and the register pointer is unchanged.
- R10: While busy, all controller strobes are ignored, and a response on the back end not being waited on is ignored.
- R11: Strobes in the same cycle resolve as pointer-load over data-write over read; only the winner takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_addr_wr | input | 1 | Load register pointer from ctl_wdata[15:0] |
| ctl_data_wr | input | 1 | Data write through the window |
| ctl_addr_rd | input | 1 | Read through the window |
| ctl_wdata | input | 32 | Controller write data |
| ctl_busy | output | 1 | Read outstanding; strobes ignored |
| ctl_rvalid | output | 1 | Read data valid pulse |
| ctl_rdata | output | 32 | Read data to controller |
| bus_wr | output | 1 | Register bus write pulse |
| bus_rd | output | 1 | Register bus read pulse |
| bus_addr | output | 16 | Register offset, bank bit cleared |
| bus_bank | output | 1 | Bank select |
| bus_wdata | output | 32 | Register write data |
| bus_rvalid | input | 1 | Register read response valid |
| bus_rdata | input | 32 | Register read response data |
| mem_wr | output | 1 | Memory write pulse |
| mem_rd | output | 1 | Memory read pulse |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Memory read response valid |
| mem_rdata | input | 32 | Memory read response data |

## Verification
A pointer that is off by one, or that moves when it should hold, shows on bus_addr or mem_addr at the next access. The checking model tracks both pointers, so the first wrong address is reported in the cycle of the strobe that used it. A wrongly classified window location shows as the wrong strobe one cycle after the request. A lost or stuck wait state shows as ctl_busy or ctl_rvalid disagreeing with the response handshake within one cycle of the response.

// File: rtl/regwin_pkg.sv
// Shared types for the register access window.
// Assumes: one operation is decided per cycle from the controller strobes.
package regwin_pkg;
    // Operation selected in a cycle
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_SETA,
        OP_REGWR,
        OP_REGRD,
        OP_MLO,
        OP_MHI,
        OP_MEMWR,
        OP_MEMRD
    } op_e;

    // Outstanding-read state
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WREG,
        ST_WMEM
    } wait_e;
endpackage

// File: rtl/regwin_decode.sv
// Turns controller strobes into one operation per cycle.
// Assumes: the pointer value decides whether an access hits a memory window location.
module regwin_decode
    import regwin_pkg::*;
#(
    parameter int AW          = 16,
    parameter int MEM_LO_LOC  = 16'h0440,
    parameter int MEM_DAT_LOC = 16'h0448
) (
    input  logic          addr_wr,
    input  logic          data_wr,
    input  logic          addr_rd,
    input  logic          busy,
    input  logic [AW-1:0] ptr,
    output op_e           op
);
    localparam logic [AW-1:0] LO_V  = AW'(MEM_LO_LOC);
    localparam logic [AW-1:0] HI_V  = AW'(MEM_LO_LOC + 1);
    localparam logic [AW-1:0] DAT_V = AW'(MEM_DAT_LOC);

    // Priority select: pointer load, then data write, then read; nothing while busy
    always_comb begin
        op = OP_IDLE;
        if (!busy) begin
            if (addr_wr) begin
                op = OP_SETA;
            end else if (data_wr) begin
                if (ptr == DAT_V)     op = OP_MEMWR;
                else if (ptr == LO_V) op = OP_MLO;
                else if (ptr == HI_V) op = OP_MHI;
                else                  op = OP_REGWR;
            end else if (addr_rd) begin
                if (ptr == DAT_V) op = OP_MEMRD;
                else              op = OP_REGRD;
            end
        end
    end
endmodule

// File: rtl/regwin_ptr.sv
// Holds the register pointer and the 64-bit memory pointer.
// Assumes: MAW - DW <= DW so the high half fits in one data word.
module regwin_ptr
    import regwin_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter int MAW      = 64,
    parameter int MEM_STEP = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  op_e            op,
    input  logic [DW-1:0]  wdata,
    output logic [AW-1:0]  ptr,
    output logic [MAW-1:0] mptr
);
    localparam int HW = MAW - DW;
    localparam logic [MAW-1:0] STEP_V = MAW'(MEM_STEP);
    localparam logic [AW-1:0]  ONE_V  = AW'(1);

    // Register pointer: load, or step by one on a register-side access (wraps)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            case (op)
                OP_SETA:                           ptr <= wdata[AW-1:0];
                OP_REGWR, OP_REGRD, OP_MLO, OP_MHI: ptr <= ptr + ONE_V;
                default:                           ptr <= ptr;
            endcase
        end
    end

    // Memory pointer: half loads, or step by one word per memory access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mptr <= '0;
        end else begin
            case (op)
                OP_MLO:             mptr[DW-1:0]  <= wdata;
                OP_MHI:             mptr[MAW-1:DW] <= wdata[HW-1:0];
                OP_MEMWR, OP_MEMRD: mptr <= mptr + STEP_V;
                default:            mptr <= mptr;
            endcase
        end
    end
endmodule

// File: rtl/regwin_issue.sv
// Drives registered bus and memory strobes and tracks the outstanding read.
// Assumes: a response is taken only from the back end being waited on.
module regwin_issue
    import regwin_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter int MAW      = 64,
    parameter int BANK_BIT = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  op_e            op,
    input  logic [AW-1:0]  ptr,
    input  logic [MAW-1:0] mptr,
    input  logic [DW-1:0]  wdata,
    input  logic           bus_rvalid,
    input  logic [DW-1:0]  bus_rdata,
    input  logic           mem_rvalid,
    input  logic [DW-1:0]  mem_rdata,
    output logic           busy,
    output logic           rvalid,
    output logic [DW-1:0]  rdata,
    output logic           bus_wr,
    output logic           bus_rd,
    output logic [AW-1:0]  bus_addr,
    output logic           bus_bank,
    output logic [DW-1:0]  bus_wdata,
    output logic           mem_wr,
    output logic           mem_rd,
    output logic [MAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata
);
    localparam logic [AW-1:0] BANK_MASK = ~(AW'(1) << BANK_BIT);

    wait_e st;
    logic  reg_op;
    logic  mem_op;

    assign reg_op = (op == OP_REGWR) || (op == OP_REGRD);
    assign mem_op = (op == OP_MEMWR) || (op == OP_MEMRD);
    assign busy   = (st != ST_IDLE);

    // One-cycle access strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_wr <= 1'b0;
            bus_rd <= 1'b0;
            mem_wr <= 1'b0;
            mem_rd <= 1'b0;
        end else begin
            bus_wr <= (op == OP_REGWR);
            bus_rd <= (op == OP_REGRD);
            mem_wr <= (op == OP_MEMWR);
            mem_rd <= (op == OP_MEMRD);
        end
    end

    // Register bus address, bank and data, held between accesses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr  <= '0;
            bus_bank  <= 1'b0;
            bus_wdata <= '0;
        end else if (reg_op) begin
            bus_addr  <= ptr & BANK_MASK;
            bus_bank  <= ptr[BANK_BIT];
            bus_wdata <= wdata;
        end
    end

    // Memory address and data, held between accesses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (mem_op) begin
            mem_addr  <= mptr;
            mem_wdata <= wdata;
        end
    end

    // Outstanding-read tracking and return of read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (op == OP_REGRD)      st <= ST_WREG;
                    else if (op == OP_MEMRD) st <= ST_WMEM;
                end
                ST_WREG: begin
                    if (bus_rvalid) begin
                        st     <= ST_IDLE;
                        rvalid <= 1'b1;
                        rdata  <= bus_rdata;
                    end
                end
                ST_WMEM: begin
                    if (mem_rvalid) begin
                        st     <= ST_IDLE;
                        rvalid <= 1'b1;
                        rdata  <= mem_rdata;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/regwin_bridge.sv
// Top of the register access window: decode, pointers and access issue.
// Assumes: controller strobes are sampled every cycle; requests while busy are dropped.
module regwin_bridge
    import regwin_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 32,
    parameter int MAW         = 64,
    parameter int BANK_BIT    = 11,
    parameter int MEM_LO_LOC  = 16'h0440,
    parameter int MEM_DAT_LOC = 16'h0448,
    parameter int MEM_STEP    = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ctl_addr_wr,
    input  logic           ctl_data_wr,
    input  logic           ctl_addr_rd,
    input  logic [DW-1:0]  ctl_wdata,
    output logic           ctl_busy,
    output logic           ctl_rvalid,
    output logic [DW-1:0]  ctl_rdata,
    output logic           bus_wr,
    output logic           bus_rd,
    output logic [AW-1:0]  bus_addr,
    output logic           bus_bank,
    output logic [DW-1:0]  bus_wdata,
    input  logic           bus_rvalid,
    input  logic [DW-1:0]  bus_rdata,
    output logic           mem_wr,
    output logic           mem_rd,
    output logic [MAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_rvalid,
    input  logic [DW-1:0]  mem_rdata
);
    op_e            op;
    logic [AW-1:0]  ptr;
    logic [MAW-1:0] mptr;

    regwin_decode #(.AW(AW), .MEM_LO_LOC(MEM_LO_LOC), .MEM_DAT_LOC(MEM_DAT_LOC)) u_dec (
        .addr_wr(ctl_addr_wr), .data_wr(ctl_data_wr), .addr_rd(ctl_addr_rd),
        .busy(ctl_busy), .ptr(ptr), .op(op)
    );

    regwin_ptr #(.AW(AW), .DW(DW), .MAW(MAW), .MEM_STEP(MEM_STEP)) u_ptr (
        .clk(clk), .rst_n(rst_n), .op(op), .wdata(ctl_wdata), .ptr(ptr), .mptr(mptr)
    );

    regwin_issue #(.AW(AW), .DW(DW), .MAW(MAW), .BANK_BIT(BANK_BIT)) u_iss (
        .clk(clk), .rst_n(rst_n), .op(op), .ptr(ptr), .mptr(mptr), .wdata(ctl_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(ctl_busy), .rvalid(ctl_rvalid), .rdata(ctl_rdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_bank(bus_bank),
        .bus_wdata(bus_wdata), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );
endmodule

// File: rtl/regwin_bridge_chk.sv
// Protocol properties of the register access window, bound to the top.
// Assumes: only port-level signals are observed.
module regwin_bridge_chk (
    input logic clk,
    input logic rst_n,
    input logic ctl_addr_wr,
    input logic ctl_busy,
    input logic ctl_rvalid,
    input logic bus_wr,
    input logic bus_rd,
    input logic bus_rvalid,
    input logic mem_wr,
    input logic mem_rd,
    input logic mem_rvalid
);
    // R11: at most one access strobe per cycle
    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_wr, bus_rd, mem_wr, mem_rd}));

    // R4: a read strobe coincides with the controller being held
    p_rd_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || mem_rd) |-> ctl_busy);

    // R4: returned data only follows a held cycle
    p_rvalid_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rvalid |-> $past(ctl_busy));

    // R10: busy persists until some response arrives
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_busy && !bus_rvalid && !mem_rvalid) |=> ctl_busy);

    // R10: no new access is issued while busy
    p_no_issue_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_busy |=> !(bus_wr || bus_rd || mem_wr || mem_rd));

    // R2: a pointer load produces no access
    p_load_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_addr_wr && !ctl_busy) |=> !(bus_wr || bus_rd || mem_wr || mem_rd));
endmodule

bind regwin_bridge regwin_bridge_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_addr_wr(ctl_addr_wr), .ctl_busy(ctl_busy),
    .ctl_rvalid(ctl_rvalid), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rvalid(bus_rvalid),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_rvalid(mem_rvalid)
);

// File: tb/regwin_bridge_tb_top.sv
// Self-checking bench: directed corners plus seeded random traffic against a pointer model.
module regwin_bridge_tb_top;
    localparam logic [15:0] LO  = 16'h0440;
    localparam logic [15:0] HI  = 16'h0441;
    localparam logic [15:0] DAT = 16'h0448;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_addr_wr = 1'b0, ctl_data_wr = 1'b0, ctl_addr_rd = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        ctl_busy, ctl_rvalid;
    logic [31:0] ctl_rdata;
    logic        bus_wr, bus_rd, bus_bank;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_rvalid = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        mem_wr, mem_rd;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;
    logic [15:0] m_ptr = '0;
    logic [63:0] m_mptr = '0;

    always #2.5 clk = ~clk;

    regwin_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_addr_wr(ctl_addr_wr), .ctl_data_wr(ctl_data_wr),
        .ctl_addr_rd(ctl_addr_rd), .ctl_wdata(ctl_wdata), .ctl_busy(ctl_busy),
        .ctl_rvalid(ctl_rvalid), .ctl_rdata(ctl_rdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_bank(bus_bank), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] exp_off(logic [15:0] p);
        return p & 16'hF7FF;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_quiet(input string req);
        logic [3:0] s;
        s = {bus_wr, bus_rd, mem_wr, mem_rd};
        chk(s == 4'b0, req, 64'(s), 64'd0);
    endtask

    task automatic set_addr(input logic [15:0] a);
        @(negedge clk);
        ctl_addr_wr = 1'b1; ctl_wdata = {16'hA5A5, a};
        @(negedge clk);
        ctl_addr_wr = 1'b0;
        chk_quiet("R2");
        m_ptr = a;
    endtask

    task automatic do_write(input logic [31:0] d);
        @(negedge clk);
        ctl_data_wr = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_data_wr = 1'b0;
        if (m_ptr == DAT) begin
            chk(mem_wr && !bus_wr, "R8", 64'({mem_wr, bus_wr}), 64'b10);
            chk(mem_addr == m_mptr, "R8", mem_addr, m_mptr);
            chk(mem_wdata == d, "R8", 64'(mem_wdata), 64'(d));
            m_mptr = m_mptr + 64'd4;
        end else if (m_ptr == LO || m_ptr == HI) begin
            chk_quiet("R7");
            if (m_ptr == LO) m_mptr[31:0] = d;
            else             m_mptr[63:32] = d;
            m_ptr = m_ptr + 16'd1;
        end else begin
            chk(bus_wr && !mem_wr, "R3", 64'({bus_wr, mem_wr}), 64'b10);
            chk(bus_addr == exp_off(m_ptr), "R6", 64'(bus_addr), 64'(exp_off(m_ptr)));
            chk(bus_bank == m_ptr[11], "R6", 64'(bus_bank), 64'(m_ptr[11]));
            chk(bus_wdata == d, "R3", 64'(bus_wdata), 64'(d));
            m_ptr = m_ptr + 16'd1;
        end
    endtask

    // Read with a response after lat cycles; optional dropped strobe and wrong-side response (R10)
    task automatic do_read(input int lat, input bit poke);
        logic [31:0] rd;
        bit is_mem;
        rd = $urandom;
        is_mem = (m_ptr == DAT);
        @(negedge clk);
        ctl_addr_rd = 1'b1;
        @(negedge clk);
        ctl_addr_rd = 1'b0;
        chk(ctl_busy, "R4", 64'(ctl_busy), 64'd1);
        if (is_mem) begin
            chk(mem_rd && !bus_rd, "R9", 64'({mem_rd, bus_rd}), 64'b10);
            chk(mem_addr == m_mptr, "R9", mem_addr, m_mptr);
            m_mptr = m_mptr + 64'd4;
        end else begin
            chk(bus_rd && !mem_rd, "R4", 64'({bus_rd, mem_rd}), 64'b10);
            chk(bus_addr == exp_off(m_ptr), "R6", 64'(bus_addr), 64'(exp_off(m_ptr)));
            chk(bus_bank == m_ptr[11], "R6", 64'(bus_bank), 64'(m_ptr[11]));
            m_ptr = m_ptr + 16'd1;
        end
        if (poke) begin
            ctl_data_wr = 1'b1; ctl_addr_wr = 1'b1; ctl_wdata = 32'h0000_0123;
            if (is_mem) mem_rvalid = 1'b0; else bus_rvalid = 1'b0;
            if (is_mem) bus_rvalid = 1'b1; else mem_rvalid = 1'b1;
            @(negedge clk);
            ctl_data_wr = 1'b0; ctl_addr_wr = 1'b0; bus_rvalid = 1'b0; mem_rvalid = 1'b0;
            chk_quiet("R10");
            chk(ctl_busy && !ctl_rvalid, "R10", 64'({ctl_busy, ctl_rvalid}), 64'b10);
        end
        for (int i = 0; i < lat; i++) @(negedge clk);
        if (is_mem) begin mem_rvalid = 1'b1; mem_rdata = rd; end
        else        begin bus_rvalid = 1'b1; bus_rdata = rd; end
        @(negedge clk);
        bus_rvalid = 1'b0; mem_rvalid = 1'b0;
        chk(ctl_rvalid && !ctl_busy, "R4", 64'({ctl_rvalid, ctl_busy}), 64'b10);
        chk(ctl_rdata == rd, is_mem ? "R9" : "R4", 64'(ctl_rdata), 64'(rd));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_quiet("R1");
        chk(!ctl_busy && !ctl_rvalid, "R1", 64'({ctl_busy, ctl_rvalid}), 64'd0);
        do_write(32'h1111_0000);                // R1: pointer starts at zero
        // R5: wrap
        set_addr(16'hFFFF);
        do_write(32'hDEAD_0001);
        do_write(32'hDEAD_0002);                // R5: lands at 0x0000
        // R6: bank crossing
        set_addr(16'h07FF);
        do_write(32'h0000_07FF);
        do_read(1, 1'b0);
        // R7, R8, R9: memory window
        set_addr(LO);
        do_write(32'h89AB_CDE0);
        do_write(32'h0000_0012);
        set_addr(DAT);
        do_write(32'h0BAD_F00D);
        do_write(32'h0BAD_F00E);
        do_read(0, 1'b0);
        do_read(2, 1'b1);
        // R11: priority between simultaneous strobes
        @(negedge clk);
        ctl_addr_wr = 1'b1; ctl_data_wr = 1'b1; ctl_addr_rd = 1'b1; ctl_wdata = 32'h0000_1234;
        @(negedge clk);
        ctl_addr_wr = 1'b0; ctl_data_wr = 1'b0; ctl_addr_rd = 1'b0;
        chk_quiet("R11");
        m_ptr = 16'h1234;
        @(negedge clk);
        ctl_data_wr = 1'b1; ctl_addr_rd = 1'b1; ctl_wdata = 32'h5555_AAAA;
        @(negedge clk);
        ctl_data_wr = 1'b0; ctl_addr_rd = 1'b0;
        chk(bus_wr && !bus_rd && bus_addr == 16'h1234, "R11", 64'({bus_wr, bus_rd, bus_addr}), 64'({2'b10, 16'h1234}));
        chk(!ctl_busy, "R11", 64'(ctl_busy), 64'd0);
        m_ptr = 16'h1235;
        // Random mix
        for (int n = 0; n < 400; n++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 2) begin
                int s;
                s = int'($urandom % 5);
                case (s)
                    0: set_addr(16'h07FE);
                    1: set_addr(16'hFFFE);
                    2: set_addr(LO);
                    3: set_addr(DAT);
                    default: set_addr(16'($urandom));
                endcase
            end else if (r < 6) begin
                do_write($urandom);
            end else begin
                do_read(int'($urandom % 4), (r == 9));
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule